// File: doc/BRIEF.md
# Dual-Core Shared Program Memory Arbiter

This block lets two processor cores share one program-memory read port. Each core brings two AHB-Lite read masters: one for instruction fetches and one for literal-pool and debug reads. The block uses the address phases of all four masters and forwards one of them to the single memory slave in each address phase. It holds the losing masters in wait states and routes the slave's read data back to the master that owns the current data phase.

Reads on the literal/debug port come first. A stalled literal read stops the core outright, while a stalled fetch is often absorbed by the core's small prefetch queue. Within a class, the two cores take turns through a round-robin pointer kept separately for each class. A master that loses has its address and size captured, so the transfer is replayed to the slave later without any action by the master.

Top module: `shared_flash_arb`

## Requirements
- R1: After reset, with all masters idle, every `m_hreadyout` bit is 1 and `s_htrans` is IDLE (2'b00).
- R2: HTRANS values IDLE (2'b00) and BUSY (2'b01) are not requests. They cause no slave transfer, leave that master's `m_hreadyout` at 1 and leave nothing to be replayed later.
- R3: A lone NONSEQ (2'b10) or SEQ (2'b11) request, made while `s_hready` is 1, appears on the slave in the same cycle as NONSEQ with the same address and size. In the following data phase, that master's `m_hreadyout` follows `s_hready`, and `m_hrdata` carries `s_hrdata`.
- R4: Master port index is 2*core + kind, where kind 0 is the fetch port and kind 1 is the data port. A fetch port is forwarded only when no data port (index 1 or 3) has a live or held request.
- R5: Within one class, contention between the two cores is settled by a per-class pointer. After reset the pointer favours core 0. After every grant in that class it favours the core that was not served.
- R6: A master that loses arbitration sees `m_hreadyout` low until its transfer has been served. Its captured address and size are replayed unchanged, and the transfers of one master reach the slave in the order it issued them.
- R7: A new transfer reaches the slave only in a cycle where `s_hready` is 1. While the slave stalls a data phase, ownership of that data phase does not change.
- R8: Every transfer accepted from a master is forwarded to the slave exactly once, and its read data is returned to that master exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_htrans | input | 4x2 | Transfer type per master (index 2*core + kind) |
| m_haddr | input | 4x32 | Address per master |
| m_hsize | input | 4x3 | Transfer size per master |
| m_hreadyout | output | 4 | Ready returned to each master |
| m_hrdata | output | DATA_W | Read data, valid for the master that owns the data phase |
| s_htrans | output | 2 | Transfer type to the memory slave |
| s_haddr | output | 32 | Address to the memory slave |
| s_hsize | output | 3 | Size to the memory slave |
| s_hready | input | 1 | Ready from the memory slave |
| s_hrdata | input | DATA_W | Read data from the memory slave |

## Verification
The bench drives all four masters at once against a memory with one wait state. A data read that slipped behind a competing fetch would show up as a fetch address on the slave while a data request was live or held. A design that replayed a wrong captured address, or dropped or repeated one, would break the per-master address sequence seen at the slave or the returned data. Runs with only two ports of the same class expose a pointer that does not turn, which gives back-to-back grants to one core. BUSY cycles followed by a real request show whether a non-request was captured as a phantom transfer.

// File: rtl/sfa_pkg.sv
package sfa_pkg;
    localparam int unsigned PA_W   = 32;
    localparam int unsigned N_CORE = 2;
    localparam int unsigned N_KIND = 2;
    localparam int unsigned N_MST  = N_CORE * N_KIND;
    localparam int unsigned MIDX_W = $clog2(N_MST);

    typedef enum logic [1:0] {
        TR_IDLE   = 2'b00,
        TR_BUSY   = 2'b01,
        TR_NONSEQ = 2'b10,
        TR_SEQ    = 2'b11
    } htrans_e;

    typedef enum logic {
        KIND_FETCH = 1'b0,
        KIND_DATA  = 1'b1
    } kind_e;

    typedef struct packed {
        logic [PA_W-1:0] addr;
        logic [2:0]      size;
    } xfer_t;
endpackage

// File: rtl/sfa_slot.sv
module sfa_slot
    import sfa_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  live_i,
    input  xfer_t xfer_i,
    input  logic  grant_i,
    output logic  req_o,
    output xfer_t xfer_o,
    output logic  pend_o
);
    typedef struct packed {
        logic  pend;
        xfer_t hold;
    } slot_st_t;

    slot_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (grant_i) begin
            st_d.pend = 1'b0;
        end else if (live_i) begin
            st_d.pend = 1'b1;
            st_d.hold = xfer_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_o  = st_q.pend | live_i;
    assign xfer_o = st_q.pend ? st_q.hold : xfer_i;
    assign pend_o = st_q.pend;

    // R6
    hold_replay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend && !grant_i) |=> (st_q.pend && $stable(st_q.hold)));
endmodule

// File: rtl/sfa_pick.sv
module sfa_pick
    import sfa_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_i,
    input  logic [N_MST-1:0]  req_i,
    output logic [N_MST-1:0]  gnt_o,
    output logic [MIDX_W-1:0] win_o,
    output logic              any_o
);
    typedef struct packed {
        logic [N_KIND-1:0] rr;
    } pick_st_t;

    pick_st_t st_q, st_d;

    logic [N_KIND-1:0] cls_req;
    logic              cls;
    logic              c0, c1, core;

    always_comb begin
        for (int k = 0; k < N_KIND; k++) begin
            cls_req[k] = req_i[k] | req_i[N_KIND + k];
        end
        cls  = cls_req[KIND_DATA] ? KIND_DATA : KIND_FETCH;
        c0   = req_i[{1'b0, cls}];
        c1   = req_i[{1'b1, cls}];
        core = (c0 && c1) ? st_q.rr[cls] : c1;
        win_o = {core, cls};
        any_o = adv_i && (cls_req != '0);
        gnt_o = '0;
        if (any_o) gnt_o[win_o] = 1'b1;
        st_d = st_q;
        if (any_o) st_d.rr[cls] = ~core;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5
    rr_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(gnt_o[1]) && req_i[1] && req_i[3] && any_o) |-> !gnt_o[1]);
endmodule

// File: rtl/shared_flash_arb.sv
module shared_flash_arb
    import sfa_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_MST-1:0][1:0]       m_htrans,
    input  logic [N_MST-1:0][PA_W-1:0]  m_haddr,
    input  logic [N_MST-1:0][2:0]       m_hsize,
    output logic [N_MST-1:0]            m_hreadyout,
    output logic [DATA_W-1:0]           m_hrdata,
    output logic [1:0]                  s_htrans,
    output logic [PA_W-1:0]             s_haddr,
    output logic [2:0]                  s_hsize,
    input  logic                        s_hready,
    input  logic [DATA_W-1:0]           s_hrdata
);
    typedef struct packed {
        logic              valid;
        logic [MIDX_W-1:0] owner;
    } dp_st_t;

    dp_st_t dp_q, dp_d;

    logic [N_MST-1:0]  live, req, pend, gnt;
    xfer_t             slot_x [N_MST];
    logic [MIDX_W-1:0] win;
    logic              any;

    always_comb begin
        for (int i = 0; i < N_MST; i++) begin
            if (dp_q.valid && dp_q.owner == MIDX_W'(i)) m_hreadyout[i] = s_hready;
            else                                       m_hreadyout[i] = !pend[i];
            live[i] = ((m_htrans[i] == TR_NONSEQ) || (m_htrans[i] == TR_SEQ)) && m_hreadyout[i];
        end
    end

    for (genvar g = 0; g < N_MST; g++) begin : g_slot
        sfa_slot u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .live_i  (live[g]),
            .xfer_i  ({m_haddr[g], m_hsize[g]}),
            .grant_i (gnt[g]),
            .req_o   (req[g]),
            .xfer_o  (slot_x[g]),
            .pend_o  (pend[g])
        );

        // R6
        loser_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pend[g] |-> !m_hreadyout[g]);
    end

    sfa_pick u_pick (
        .clk   (clk),
        .rst_n (rst_n),
        .adv_i (s_hready),
        .req_i (req),
        .gnt_o (gnt),
        .win_o (win),
        .any_o (any)
    );

    always_comb begin
        s_htrans = any ? TR_NONSEQ : TR_IDLE;
        s_haddr  = any ? slot_x[win].addr : '0;
        s_hsize  = any ? slot_x[win].size : '0;
        dp_d     = dp_q;
        if (s_hready) begin
            dp_d.valid = any;
            if (any) dp_d.owner = win;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dp_q <= '0;
        else        dp_q <= dp_d;
    end

    assign m_hrdata = s_hrdata;

    // R4
    data_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (any && win[0] == KIND_FETCH) |-> !(req[1] || req[3]));

    // R7
    dphase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_q.valid && !s_hready) |=> (dp_q.valid && $stable(dp_q.owner)));

    // R3
    lone_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_hready && $countones(req) == 1) |-> (s_htrans == TR_NONSEQ));
endmodule

// File: tb/tb_shared_flash_arb.sv
module tb_shared_flash_arb;
    logic clk = 1'b0;
    logic rst_n;
    logic [3:0][1:0]  m_htrans;
    logic [3:0][31:0] m_haddr;
    logic [3:0][2:0]  m_hsize;
    logic [3:0]       m_hreadyout;
    logic [31:0]      m_hrdata;
    logic [1:0]       s_htrans;
    logic [31:0]      s_haddr;
    logic [2:0]       s_hsize;
    logic             s_hready;
    logic [31:0]      s_hrdata;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    shared_flash_arb #(.DATA_W(32)) dut (
        .clk(clk), .rst_n(rst_n),
        .m_htrans(m_htrans), .m_haddr(m_haddr), .m_hsize(m_hsize),
        .m_hreadyout(m_hreadyout), .m_hrdata(m_hrdata),
        .s_htrans(s_htrans), .s_haddr(s_haddr), .s_hsize(s_hsize),
        .s_hready(s_hready), .s_hrdata(s_hrdata)
    );

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return {a[15:0], ~a[15:0]} ^ 32'h5A3C_0000;
    endfunction

    function automatic logic [31:0] base(input int i);
        return 32'((i + 1) << 12);
    endfunction

    // one-wait-state memory
    logic [1:0]  sl_ph;
    logic [31:0] sl_addr;
    assign s_hready = (sl_ph != 2'd1);
    assign s_hrdata = (sl_ph == 2'd2) ? mem_word(sl_addr) : 32'h0;
    always @(posedge clk) begin
        if (!rst_n)                 sl_ph <= 2'd0;
        else if (sl_ph == 2'd1)     sl_ph <= 2'd2;
        else if (s_htrans[1]) begin sl_ph <= 2'd1; sl_addr <= s_haddr; end
        else                        sl_ph <= 2'd0;
    end

    int n_todo[4], start_at[4], issued[4], got[4], acc[4];
    bit dp_busy[4];
    logic [31:0] dp_addr[4];
    int bad_data, order_err, prio_err, stall_err, gcnt;
    int glog[64];

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic idle_all();
        for (int i = 0; i < 4; i++) begin
            m_htrans[i] = 2'b00;
            m_haddr[i]  = 32'h0;
            m_hsize[i]  = 3'b010;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle_all();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic clear_engine();
        for (int i = 0; i < 4; i++) begin
            n_todo[i] = 0; start_at[i] = 0; issued[i] = 0; got[i] = 0; acc[i] = 0;
            dp_busy[i] = 1'b0; dp_addr[i] = 32'h0;
        end
        bad_data = 0; order_err = 0; prio_err = 0; stall_err = 0; gcnt = 0;
        for (int k = 0; k < 64; k++) glog[k] = -1;
    endtask

    task automatic run_engine(input int limit);
        int cyc = 0;
        bit done = 1'b0;
        while (!done && cyc < limit) begin
            @(negedge clk);
            for (int i = 0; i < 4; i++) begin
                if (issued[i] < n_todo[i] && cyc >= start_at[i]) begin
                    m_htrans[i] = 2'b10;
                    m_haddr[i]  = base(i) + 32'(4 * issued[i]);
                end else begin
                    m_htrans[i] = 2'b00;
                    m_haddr[i]  = 32'h0;
                end
            end
            #8;
            if (s_htrans[1]) begin
                if (!s_hready) stall_err++;
                else begin
                    int r;
                    r = int'(s_haddr[15:12]) - 1;
                    if (r < 0 || r > 3) order_err++;
                    else begin
                        if (s_haddr != base(r) + 32'(4 * acc[r])) order_err++;
                        if (r % 2 == 0) begin
                            for (int d = 1; d < 4; d += 2) begin
                                if ((issued[d] > acc[d]) || (m_htrans[d][1] && m_hreadyout[d]))
                                    prio_err++;
                            end
                        end
                        acc[r]++;
                        if (gcnt < 64) glog[gcnt] = r;
                        gcnt++;
                    end
                end
            end
            for (int i = 0; i < 4; i++) begin
                if (m_hreadyout[i]) begin
                    if (dp_busy[i]) begin
                        if (m_hrdata != mem_word(dp_addr[i])) bad_data++;
                        got[i]++;
                    end
                    dp_busy[i] = m_htrans[i][1];
                    if (m_htrans[i][1]) begin
                        dp_addr[i] = m_haddr[i];
                        issued[i]++;
                    end
                end
            end
            cyc++;
            done = 1'b1;
            for (int i = 0; i < 4; i++) if (got[i] != n_todo[i]) done = 1'b0;
        end
        @(negedge clk);
        idle_all();
        check(done, "R8", "engine completion", longint'(done), 1);
    endtask

    task automatic t_reset();
        do_reset();
        #8;
        check(m_hreadyout == 4'hF, "R1", "hreadyout after reset", m_hreadyout, 15);
        check(s_htrans == 2'b00, "R1", "s_htrans after reset", s_htrans, 0);
    endtask

    task automatic t_idle_busy();
        int errs = 0;
        do_reset();
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            m_htrans[1] = (k < 2) ? 2'b00 : 2'b01;
            m_haddr[1]  = 32'h0000_2FF0;
            #8;
            if (s_htrans != 2'b00 || m_hreadyout != 4'hF) errs++;
        end
        @(negedge clk);
        idle_all();
        check(errs == 0, "R2", "idle/busy cycles forwarded", errs, 0);
        clear_engine();
        n_todo[1] = 1;
        run_engine(50);
        check(acc[1] == 1 && order_err == 0, "R2", "phantom replay after busy", order_err, 0);
    endtask

    task automatic t_single();
        logic [31:0] a = 32'h0000_3040;
        do_reset();
        @(negedge clk);
        m_htrans[2] = 2'b10;
        m_haddr[2]  = a;
        #8;
        check(s_htrans == 2'b10 && s_haddr == a && s_hsize == 3'b010, "R3",
              "same-cycle forward addr", s_haddr, a);
        @(negedge clk);
        idle_all();
        #8;
        check(m_hreadyout[2] == 1'b0, "R3", "wait state seen by master", m_hreadyout[2], 0);
        @(negedge clk);
        #8;
        check(m_hreadyout[2] == 1'b1, "R3", "data phase done", m_hreadyout[2], 1);
        check(m_hrdata == mem_word(a), "R3", "read data", m_hrdata, mem_word(a));
    endtask

    task automatic t_rr_pair(input int lo, input int hi, input int n);
        int alt = 0;
        do_reset();
        clear_engine();
        n_todo[lo] = n;
        n_todo[hi] = n;
        run_engine(400);
        for (int k = 0; k < 2 * n; k++) begin
            if (glog[k] != ((k % 2 == 0) ? lo : hi)) alt++;
        end
        check(alt == 0, "R5", "round-robin alternation errors", alt, 0);
        check(got[lo] == n && got[hi] == n && bad_data == 0, "R8", "pair delivery", bad_data, 0);
    endtask

    task automatic t_all();
        int nondata = 0;
        do_reset();
        clear_engine();
        for (int i = 0; i < 4; i++) n_todo[i] = 8;
        run_engine(600);
        for (int k = 0; k < 16; k++) if (glog[k] % 2 == 0) nondata++;
        check(prio_err == 0, "R4", "fetch forwarded over waiting data", prio_err, 0);
        check(nondata == 0, "R4", "fetches among first 16 grants", nondata, 0);
        check(order_err == 0, "R6", "replay address/order errors", order_err, 0);
        check(stall_err == 0, "R7", "transfer while slave stalled", stall_err, 0);
        check(gcnt == 32 && bad_data == 0, "R8", "slave transfers", gcnt, 32);
    endtask

    task automatic t_staggered();
        do_reset();
        clear_engine();
        n_todo[0] = 5; start_at[0] = 0;
        n_todo[3] = 4; start_at[3] = 1;
        n_todo[2] = 6; start_at[2] = 3;
        n_todo[1] = 3; start_at[1] = 7;
        run_engine(600);
        check(order_err == 0, "R6", "staggered replay order", order_err, 0);
        check(prio_err == 0, "R4", "staggered priority", prio_err, 0);
        check(gcnt == 18 && bad_data == 0, "R8", "staggered transfers", gcnt, 18);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        idle_all();
        clear_engine();
        t_reset();
        t_idle_busy();
        t_single();
        t_rr_pair(1, 3, 6);
        t_rr_pair(0, 2, 5);
        t_all();
        t_staggered();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule